// File: doc/BRIEF.md
# Delayed Cascadable Parity Checker

This block checks the parity of a 10-bit data word against a parity bit that arrives one clock after the word. It reports the result one clock after the parity bit has been taken. The data word is captured on one rising edge. The parity bit, the select/partial-sum input and the error-enable bit are captured on the following edge. The active-low error flag is updated on the edge after that.

A single parity port has two roles, chosen by a control input. In standalone use the port is an input. On its own it selects even or odd parity. In a cascade it carries the partial sum from the first device. When the port drives, it outputs the XOR of the held data word and the current parity input, so a second checker can fold that sum into its own check. This extends the check to a 20-bit word.

The error flag has open-drain semantics. A separate enable says when the pin actively pulls low. An output-enable input releases the pin but leaves the internal state untouched.

Top module: `lagged_parity_checker`

## Requirements
- R1: A data word captured on edge k is checked against the parity bit captured on edge k+1, never against the parity bit of a neighbouring word.
- R2: `errN` changes only on the edge after the parity bit is captured (edge k+2), and holds its value between updates.
- R3: With `sumOeN` = 1 and `selIn` = 0 (even parity), `errN` goes to 0 when the number of ones in the data word plus the parity bit is odd, and to 1 otherwise.
- R4: With `sumOeN` = 1 and `selIn` = 1 (odd parity), `errN` goes to 0 when that total is even, and to 1 otherwise.
- R5: With `sumOeN` = 0, `selDrive` is 1 and `selOut` equals the XOR of the last captured data word and the present `parIn`. The check then treats the select term as 0, so `selIn` has no effect on `errN`.
- R6: When `errEnIn` is 1 on the parity edge, the `errN` value written on the next edge is 1.
- R7: `errPullLow` is 1 exactly when `outEnN` is 0 and `errN` is 0. `outEnN` does not alter `errN`.
- R8: From reset, and for the first two rising edges after reset is released, `errN` reads 1.
- R9: In a cascade, the second device takes the first device's `selOut` on `selIn`, and its `errN` flags an odd count of ones over both 10-bit words plus both parity bits.
- R10: With `sumOeN` = 1, `selDrive` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | DATA_W | Data word under check |
| parIn | input | 1 | Parity bit, presented one cycle after its word |
| errEnIn | input | 1 | 1 suppresses the error for the word whose parity edge it meets |
| sumOeN | input | 1 | 0: the parity port drives the partial sum; 1: the port is an input |
| outEnN | input | 1 | 1 releases the error pin |
| selIn | input | 1 | Input side of the parity port: parity select or incoming partial sum |
| selOut | output | 1 | Output side of the parity port: XOR of held word and current parity bit |
| selDrive | output | 1 | Drive enable for the parity port |
| errN | output | 1 | Registered active-low error value |
| errPullLow | output | 1 | Open-drain enable: 1 while the error pin pulls low |

## Verification
Assertions check four things on every cycle:
- The two-edge pipeline timing of `errN` against the port history, so that each word stays paired with the parity bit taken one edge later.
- The quiet period after reset.
- Suppression by the error-enable bit.
- The value on the partial-sum output.

The bench scenarios show the rest:
- Even and odd selection.
- `selIn` having no effect while the port drives.
- The released error pin, with the internal flag still tracking.
- A real two-device cascade checked against a 20-bit reference parity.
- A reset in the middle of a run.

// File: rtl/lpc_pkg.sv
`timescale 1ns/1ps
package lpc_pkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic dataValid;  // stage-1 register holds a word captured after reset
    logic chkValid;   // stage-2 registers hold a full word/parity pair
    logic useSel;     // fold selIn into the check (port acts as input)
    logic sumDrive;   // port drives the partial sum
    logic pinDrive;   // error pin may pull low
  } lpcStrobeT;

endpackage

// File: rtl/lpc_ctrl.sv
`timescale 1ns/1ps
module lpc_ctrl
  import lpc_pkg::*;
#(
  parameter int FILL_DEPTH = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sumOeN,
  input  logic      outEnN,
  output lpcStrobeT strb
);

  localparam int CNT_W = $clog2(FILL_DEPTH + 1);

  logic [CNT_W-1:0] fillCnt;

  // Counts edges since reset until the pipeline is full
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (fillCnt != CNT_W'(FILL_DEPTH)) begin
      fillCnt <= fillCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strb.dataValid = (fillCnt >= CNT_W'(1));
    strb.chkValid  = (fillCnt >= CNT_W'(FILL_DEPTH));
    strb.useSel    = sumOeN;
    strb.sumDrive  = !sumOeN;
    strb.pinDrive  = !outEnN;
  end

  AST_FILL_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.chkValid) |-> $past(strb.dataValid)); // R8

endmodule

// File: rtl/lpc_datapath.sv
`timescale 1ns/1ps
module lpc_datapath
  import lpc_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpcStrobeT         strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              parIn,
  input  logic              selIn,
  input  logic              errEnIn,
  output logic              errN,
  output logic              selOut,
  output logic              errPullLow
);

  logic [DATA_W-1:0] dataReg;
  logic [DATA_W:0]   xorChain;
  logic              wordPar;
  logic              wordParReg;
  logic              parReg;
  logic              selReg;
  logic              errEnReg;
  logic              checkBit;

  // Stage 1: capture the data word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataReg <= '0;
    else       dataReg <= dataIn;
  end

  // XOR chain over the held word
  assign xorChain[0] = 1'b0;
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_xor
      assign xorChain[i+1] = xorChain[i] ^ dataReg[i];
    end
  endgenerate
  assign wordPar = xorChain[DATA_W];

  // Stage 2: reduced word parity plus the late-arriving bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordParReg <= 1'b0;
      parReg     <= 1'b0;
      selReg     <= 1'b0;
      errEnReg   <= 1'b1;
    end else begin
      wordParReg <= wordPar;
      parReg     <= parIn;
      selReg     <= strb.useSel ? selIn : 1'b0;
      errEnReg   <= errEnIn;
    end
  end

  assign checkBit = wordParReg ^ parReg ^ selReg;

  // Stage 3: registered active-low error flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errN <= 1'b1;
    end else if (strb.chkValid) begin
      errN <= !(checkBit && !errEnReg);
    end
  end

  assign selOut     = wordPar ^ parIn;
  assign errPullLow = strb.pinDrive && !errN;

  AST_ERR_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.chkValid) |-> errN == !(((^$past(dataIn, 3)) ^ $past(parIn, 2) ^
      ($past(strb.useSel, 2) ? $past(selIn, 2) : 1'b0)) && !$past(errEnIn, 2))); // R2

  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.chkValid |=> $stable(errN)); // R8

  AST_SUPPRESS: assert property (@(posedge clk) disable iff (!rstN)
    errEnIn |=> ##1 errN); // R6

  AST_PARTIAL_SUM: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataValid |-> selOut == ((^$past(dataIn)) ^ parIn)); // R5

endmodule

// File: rtl/lagged_parity_checker.sv
`timescale 1ns/1ps
module lagged_parity_checker
  import lpc_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              parIn,
  input  logic              errEnIn,
  input  logic              sumOeN,
  input  logic              outEnN,
  input  logic              selIn,
  output logic              selOut,
  output logic              selDrive,
  output logic              errN,
  output logic              errPullLow
);

  localparam int FILL_DEPTH = 2;

  lpcStrobeT strb;

  lpc_ctrl #(.FILL_DEPTH(FILL_DEPTH)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sumOeN (sumOeN),
    .outEnN (outEnN),
    .strb   (strb)
  );

  lpc_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .dataIn     (dataIn),
    .parIn      (parIn),
    .selIn      (selIn),
    .errEnIn    (errEnIn),
    .errN       (errN),
    .selOut     (selOut),
    .errPullLow (errPullLow)
  );

  assign selDrive = strb.sumDrive;

endmodule

// File: tb/lagged_parity_checker_tb_top.sv
`timescale 1ns/1ps
module lagged_parity_checker_tb_top;

  localparam int W = 10;

  typedef struct packed {
    logic [W-1:0] dA;
    logic [W-1:0] dB;
    logic         pA;
    logic         pB;
    logic         sel;
    logic         en;
    logic         sumOeN;
    logic         outEnN;
    logic         casc;
  } smpT;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN;
  smpT  cur, h1, h2, h3;
  int   edges;
  int   nChk = 0;
  int   nFail = 0;
  bit   done = 1'b0;

  logic leadSel, leadDrv, leadErrN, leadPull;
  logic selOut, selDrive, errN, errPullLow;
  logic dutSel;

  assign dutSel = cur.casc ? leadSel : cur.sel;

  // First device of the pair: always drives its partial sum
  lagged_parity_checker #(.DATA_W(W)) lead_i (
    .clk(clk), .rstN(rstN), .dataIn(cur.dA), .parIn(cur.pA), .errEnIn(1'b1),
    .sumOeN(1'b0), .outEnN(1'b1), .selIn(1'b0), .selOut(leadSel),
    .selDrive(leadDrv), .errN(leadErrN), .errPullLow(leadPull)
  );

  lagged_parity_checker #(.DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .dataIn(cur.dB), .parIn(cur.pB), .errEnIn(cur.en),
    .sumOeN(cur.sumOeN), .outEnN(cur.outEnN), .selIn(dutSel), .selOut(selOut),
    .selDrive(selDrive), .errN(errN), .errPullLow(errPullLow)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b (edge %0d)", req, act, exp, edges);
    end
  endtask

  // Reference: errN from the data word captured two edges ago and bits captured one edge ago
  function automatic logic expErrN(input smpT dOld, input smpT pOld);
    logic s;
    s = !pOld.sumOeN ? 1'b0 : (pOld.casc ? ((^dOld.dA) ^ pOld.pA) : pOld.sel);
    return !(((^dOld.dB) ^ pOld.pB ^ s) && !pOld.en);
  endfunction

  function automatic string pickTag(input string force_tag);
    if (force_tag != "") return force_tag;
    if (edges < 3)       return "R8";
    if (h2.casc)         return "R9";
    if (h2.en)           return "R6";
    if (cur.outEnN)      return "R7";
    if (!h2.sumOeN)      return "R5";
    if (h2.sel)          return "R4";
    return "R3";
  endfunction

  task automatic cycle(input string force_tag);
    logic e;
    @(posedge clk);
    edges++;
    h3 = h2; h2 = h1; h1 = cur;
    @(negedge clk);
    e = (edges >= 3) ? expErrN(h3, h2) : 1'b1;
    chk(pickTag(force_tag), errN, e);
    chk("R7", errPullLow, !cur.outEnN && !e);
    if (cur.sumOeN) chk("R10", selDrive, 1'b0);
    else begin
      chk("R5", selDrive, 1'b1);
      chk("R5", selOut, (^h1.dB) ^ cur.pB);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8", errN, 1'b1);
    rstN = 1'b1;
    edges = 0;
    h1 = '0; h2 = '0; h3 = '0;
    chk("R8", errN, 1'b1);
    chk("R10", selDrive, !cur.sumOeN);
    chk("R7", errPullLow, 1'b0);
  endtask

  function automatic logic rnd(input int oneIn);
    return ($urandom % oneIn) == 0;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    cur = '0;
    cur.sumOeN = 1'b1;
    h1 = '0; h2 = '0; h3 = '0;
    edges = 0;
    doReset();

    // R8: bad words during the fill stay unreported
    cur.dB = 10'h001; cur.pB = 1'b0;
    cycle("");
    cycle("");

    // R1: pairing of each word with the next-edge parity bit
    cur.dB = 10'h3FF; cur.pB = 1'b1;      // pB here belongs to 0x001 word
    cycle("");
    cur.dB = 10'h001; cur.pB = 1'b0;      // 0x3FF + 0 -> ok
    cycle("R1");
    cur.dB = 10'h000; cur.pB = 1'b0;      // 0x001 + 0 -> error
    cycle("R1");
    cur.pB = 1'b1;
    cycle("R1");
    cycle("R1");

    // R3/R4/R6/R7: standalone random traffic
    for (int i = 0; i < 400; i++) begin
      cur.dB     = W'($urandom);
      cur.pB     = rnd(2);
      cur.sel    = (i >= 200);
      cur.en     = rnd(8);
      cur.outEnN = rnd(6);
      cycle("");
    end

    // R4: odd-parity corner words
    cur.sel = 1'b1; cur.en = 1'b0; cur.outEnN = 1'b0;
    cur.dB = '0; cur.pB = 1'b0;
    cycle("");
    cur.dB = '1; cur.pB = 1'b0;
    cycle("");
    cur.pB = 1'b1;
    cycle("");
    cycle("");
    cycle("");

    // R7: pin released, internal flag keeps tracking
    cur.outEnN = 1'b1; cur.sel = 1'b0;
    cur.dB = 10'h003; cur.pB = 1'b0;
    cycle("R7");
    cur.pB = 1'b1;
    cycle("R7");
    cycle("R7");
    cur.outEnN = 1'b0;
    cycle("R7");

    // R5: port drives, selIn toggles freely
    cur.sumOeN = 1'b0;
    for (int i = 0; i < 150; i++) begin
      cur.dB  = W'($urandom);
      cur.pB  = rnd(2);
      cur.sel = rnd(2);
      cur.en  = rnd(10);
      cycle("");
    end

    // R8: reset in the middle of traffic
    cur.sumOeN = 1'b1; cur.en = 1'b0; cur.sel = 1'b0;
    cur.dB = 10'h007; cur.pB = 1'b0;
    doReset();
    cycle("");
    cycle("");

    // R9: two-device cascade against a 20-bit reference
    cur.casc = 1'b1;
    cur.dA = 10'h001; cur.dB = '0; cur.pA = 1'b0; cur.pB = 1'b0;
    cycle("");
    cur.dA = '0;
    cycle("");
    cycle("R9");
    for (int i = 0; i < 400; i++) begin
      cur.dA     = W'($urandom);
      cur.dB     = W'($urandom);
      cur.pA     = rnd(2);
      cur.pB     = rnd(2);
      cur.en     = rnd(12);
      cur.outEnN = rnd(8);
      cycle("");
    end
    cur.en = 1'b0; cur.dA = '1; cur.dB = '1; cur.pA = 1'b1; cur.pB = 1'b0;
    cycle("");
    cycle("");
    cycle("R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule